// File: doc/BRIEF.md
# Block-Move DMA Address Composer

This block turns a decoded block-move instruction into a stream of DMA chunks. It accepts a direct, indirect or descriptor-table move together with a three-bit mode field, a descriptor base register and a bank of 32-bit source registers. It produces, for every chunk the downstream data mover accepts, a 64-bit bus address and a byte length. For indirect moves it fetches the low address from memory. For table moves it fetches a two-dword descriptor. The upper 32 address bits come either from the descriptor or from a fixed priority of selector registers, depending on the mode bits.

A move begins with a single-cycle `start` while the block is idle. The block then fetches from memory as the move type requires and walks the transfer. Each chunk is the smaller of the bytes still owed and the bytes the mover reports as available. Each accepted chunk advances the low address, reduces the remaining count and adds to a running byte total. The block also returns the updated script pointer and the address of the instruction it consumed.

Top module: `bm_addr_composer`

## Requirements
- R1: After reset `busy`, `done`, `chunkValid` and `errIllegal` are low, and `totalCount` and the dynamic selector register are zero.
- R2: Mode field bits are named as follows. Bit 0 enables direct 64-bit moves. Bit 1 enables descriptor 64-bit moves. Bit 2 refines bit 1. Forty-bit mode is active only when bits 2 and 1 are both set, and in that mode a table move takes its upper address bits from bits 31:24 of descriptor dword 0. With bit 2 alone set, neither wide mode is active.
- R3: A table move reads descriptor dword 0 at `descBase` plus the sign-extended `insnArg[23:0]`, then dword 1 at that address plus 4. The byte count is dword 0 bits 23:0 and the low address is dword 1. `memAddr` is held steady while a read waits for `memRdValid`.
- R4: With bit 1 set and 40-bit mode off, dword 0 bits 28:24 select the upper bits. Values 0..15 select scratch slot k (`scratchBank[32k+31:32k]`). Value 16 selects `mmRdSel`, 17 `mmWrSel`, 18 `fetchSel`, 19 `dynRegSel`, 20 `staticSel` and 21 the internal dynamic selector register.
- R5: A selector above 21 in that mode sets `errIllegal`, pulses `done`, loads zero upper bits and returns to idle with no chunk issued. `errIllegal` stays set until the next accepted `start`.
- R6: A direct move (`moveKind`=0) with mode bit 0 set loads `insnExtra` into the dynamic selector register and reports `nextPtr` = `scriptPtr`+4. Otherwise `nextPtr` = `scriptPtr`. In both cases `instAddr` = `scriptPtr`-8.
- R7: The upper half of `chunkAddr` is chosen as follows, in this order. If either wide mode is active, it is the stored upper register (zero for non-table moves). Otherwise it is the dynamic selector if that is nonzero. Otherwise it is `staticSel` if that is nonzero. Otherwise it is zero.
- R8: `chunkValid` is high only during a transfer, with bytes remaining and `availLen` nonzero. `chunkLen` equals the smaller of the remaining count and `availLen`.
- R9: On each cycle with `chunkValid` and `chunkReady` both high, the low address and `totalCount` increase by `chunkLen` and the remaining count falls by it. On any other cycle they do not change.
- R10: An indirect move (`moveKind`=1) reads one dword at `insnArg` and uses it as the low address. The byte count comes from `insnCount`.
- R11: `done` pulses for one cycle when the remaining count is zero in the transfer phase. A zero count therefore finishes with no chunk.
- R12: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (idle only) |
| moveKind | input | 2 | 0 direct, 1 indirect, 2 table |
| modeCtl | input | 3 | Mode field bits 2:0 |
| insnCount | input | 24 | Byte count from the instruction |
| insnArg | input | 32 | Instruction address / table offset dword |
| insnExtra | input | 32 | Third instruction dword |
| scriptPtr | input | 32 | Script pointer past the first two dwords |
| descBase | input | 32 | Descriptor base address |
| scratchBank | input | 512 | Sixteen scratch registers, slot 0 lowest |
| mmRdSel | input | 32 | Memory-move read selector |
| mmWrSel | input | 32 | Memory-move write selector |
| fetchSel | input | 32 | Script fetch selector |
| dynRegSel | input | 32 | Dynamic register selector |
| staticSel | input | 32 | Static block-move selector |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| availLen | input | 24 | Bytes the mover can take now |
| chunkValid | output | 1 | Chunk offered |
| chunkReady | input | 1 | Chunk accepted |
| chunkAddr | output | 64 | Composed chunk address |
| chunkLen | output | 24 | Chunk byte length |
| busy | output | 1 | Move in progress |
| done | output | 1 | Move finished or aborted (pulse) |
| errIllegal | output | 1 | Illegal selector seen |
| totalCount | output | 32 | Cumulative bytes issued |
| nextPtr | output | 32 | Updated script pointer |
| instAddr | output | 32 | Address of the consumed instruction |

## Verification
A stale or wrong low address, remaining count or stored upper register shows on `chunkAddr` or `chunkLen` at the very next offered chunk. A missed update shows in `totalCount` one cycle after an acceptance. A wrong descriptor address shows on `memAddr` in the first fetch cycle. A control state that strays from the model shows within a cycle as a difference in `busy`, `memRdEn`, `chunkValid` or `done`. The reference model is compared on every clock, so each of these differences is reported at the cycle where it first appears.

// File: rtl/bm_addr_pkg.sv
package bm_addr_pkg;
  localparam int DW        = 32;
  localparam int CNT_W     = 24;
  localparam int TOT_W     = 32;
  localparam int MODE_W    = 3;
  localparam int SEL_W     = 5;
  localparam int N_SCRATCH = 16;
  localparam int N_AUX     = 6;
  localparam int N_SRC     = N_SCRATCH + N_AUX;
  localparam int SEL_LSB   = 24;
  localparam int HI8_LSB   = 24;
  localparam int HI8_W     = 8;
  localparam int DESC_STEP = 4;
  localparam int PTR_EXTRA = 4;
  localparam int PTR_BACK  = 8;

  localparam int MB_DIR64 = 0;
  localparam int MB_TI64  = 1;
  localparam int MB_TIMOD = 2;

  typedef enum logic [1:0] {
    MV_DIRECT   = 2'd0,
    MV_INDIRECT = 2'd1,
    MV_TABLE    = 2'd2
  } moveKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IND, ST_TBL0, ST_TBL1, ST_XFER
  } ctlState_e;

  typedef struct packed {
    logic capture;
    logic rdInd;
    logic rdTbl0;
    logic rdTbl1;
    logic xfer;
    logic setErr;
  } dpCtl_t;
endpackage

// File: rtl/bm_addr_ctrl.sv
module bm_addr_ctrl
  import bm_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] moveKind,
  input  logic       memRdValid,
  input  logic       remainZero,
  input  logic       selIllegal,
  output dpCtl_t     ctl,
  output logic       memRdEn,
  output logic       busy,
  output logic       done
);
  ctlState_e stQ, stNxt;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNxt;
  end

  always_comb begin
    stNxt = stQ;
    ctl   = '0;
    done  = 1'b0;
    case (stQ)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          case (moveKind)
            MV_INDIRECT: stNxt = ST_IND;
            MV_TABLE:    stNxt = ST_TBL0;
            default:     stNxt = ST_XFER;
          endcase
        end
      end
      ST_IND: begin
        ctl.rdInd = 1'b1;
        if (memRdValid) stNxt = ST_XFER;
      end
      ST_TBL0: begin
        ctl.rdTbl0 = 1'b1;
        if (memRdValid) stNxt = ST_TBL1;
      end
      ST_TBL1: begin
        ctl.rdTbl1 = 1'b1;
        if (memRdValid) begin
          if (selIllegal) begin
            ctl.setErr = 1'b1;
            done       = 1'b1;
            stNxt      = ST_IDLE;
          end else begin
            stNxt = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        ctl.xfer = 1'b1;
        if (remainZero) begin
          done  = 1'b1;
          stNxt = ST_IDLE;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  assign memRdEn = ctl.rdInd | ctl.rdTbl0 | ctl.rdTbl1;
  assign busy    = (stQ != ST_IDLE);
endmodule

// File: rtl/bm_addr_dp.sv
module bm_addr_dp
  import bm_addr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [1:0]              moveKind,
  input  logic [MODE_W-1:0]       modeCtl,
  input  logic [CNT_W-1:0]        insnCount,
  input  logic [DW-1:0]           insnArg,
  input  logic [DW-1:0]           insnExtra,
  input  logic [DW-1:0]           scriptPtr,
  input  logic [DW-1:0]           descBase,
  input  logic [N_SCRATCH*DW-1:0] scratchBank,
  input  logic [DW-1:0]           mmRdSel,
  input  logic [DW-1:0]           mmWrSel,
  input  logic [DW-1:0]           fetchSel,
  input  logic [DW-1:0]           dynRegSel,
  input  logic [DW-1:0]           staticSel,
  input  logic                    memRdValid,
  input  logic [DW-1:0]           memRdData,
  input  logic [CNT_W-1:0]        availLen,
  input  logic                    chunkReady,
  output logic [DW-1:0]           memAddr,
  output logic                    chunkValid,
  output logic [2*DW-1:0]         chunkAddr,
  output logic [CNT_W-1:0]        chunkLen,
  output logic                    errIllegal,
  output logic [TOT_W-1:0]        totalCount,
  output logic [DW-1:0]           nextPtr,
  output logic [DW-1:0]           instAddr,
  output logic                    remainZero,
  output logic                    selIllegal
);
  logic [MODE_W-1:0] modeQ;
  logic [DW-1:0]     lowQ, upperQ, dynSelQ, tblQ, desc0Q, nextQ, instQ;
  logic [CNT_W-1:0]  remainQ;
  logic [TOT_W-1:0]  totalQ;
  logic              errQ;

  // upper-bit source bank: scratch slots, then the six selector registers
  logic [DW-1:0] srcBank [N_SRC];
  for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
    assign srcBank[i] = scratchBank[i*DW +: DW];
  end
  assign srcBank[N_SCRATCH+0] = mmRdSel;
  assign srcBank[N_SCRATCH+1] = mmWrSel;
  assign srcBank[N_SCRATCH+2] = fetchSel;
  assign srcBank[N_SCRATCH+3] = dynRegSel;
  assign srcBank[N_SCRATCH+4] = staticSel;
  assign srcBank[N_SCRATCH+5] = dynSelQ;

  logic             wide40, wideTi;
  logic [SEL_W-1:0] selIdx;
  logic [DW-1:0]    selVal;
  assign wide40 = modeQ[MB_TIMOD] & modeQ[MB_TI64];
  assign wideTi = modeQ[MB_TI64];
  assign selIdx = desc0Q[SEL_LSB +: SEL_W];
  assign selIllegal = wideTi && !wide40 && (selIdx > SEL_W'(N_SRC-1));

  always_comb begin
    selVal = '0;
    for (int i = 0; i < N_SRC; i++)
      if (selIdx == SEL_W'(i)) selVal = srcBank[i];
  end

  logic [DW-1:0] upperNew;
  always_comb begin
    if (wide40)                   upperNew = DW'(desc0Q[HI8_LSB +: HI8_W]);
    else if (wideTi && !selIllegal) upperNew = selVal;
    else                          upperNew = '0;
  end

  logic dir64;
  assign dir64 = modeCtl[MB_DIR64] && (moveKind != MV_INDIRECT) && (moveKind != MV_TABLE);

  logic fire;
  assign chunkValid = ctl.xfer && (remainQ != '0) && (availLen != '0);
  assign chunkLen   = (remainQ < availLen) ? remainQ : availLen;
  assign fire       = chunkValid && chunkReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0; lowQ <= '0; upperQ <= '0; dynSelQ <= '0; tblQ <= '0;
      desc0Q <= '0; nextQ <= '0; instQ <= '0; remainQ <= '0; totalQ <= '0;
      errQ <= 1'b0;
    end else begin
      if (ctl.capture) begin
        modeQ   <= modeCtl;
        remainQ <= insnCount;
        lowQ    <= insnArg;
        upperQ  <= '0;
        errQ    <= 1'b0;
        tblQ    <= descBase + {{(DW-CNT_W){insnArg[CNT_W-1]}}, insnArg[CNT_W-1:0]};
        instQ   <= scriptPtr - DW'(PTR_BACK);
        nextQ   <= dir64 ? scriptPtr + DW'(PTR_EXTRA) : scriptPtr;
        if (dir64) dynSelQ <= insnExtra;
      end
      if (ctl.rdInd && memRdValid) lowQ <= memRdData;
      if (ctl.rdTbl0 && memRdValid) begin
        desc0Q  <= memRdData;
        remainQ <= memRdData[CNT_W-1:0];
      end
      if (ctl.rdTbl1 && memRdValid) begin
        lowQ   <= memRdData;
        upperQ <= upperNew;
      end
      if (ctl.setErr) errQ <= 1'b1;
      if (fire) begin
        lowQ    <= lowQ + DW'(chunkLen);
        remainQ <= remainQ - chunkLen;
        totalQ  <= totalQ + TOT_W'(chunkLen);
      end
    end
  end

  logic [DW-1:0] upperOut;
  always_comb begin
    if (wide40 || wideTi)    upperOut = upperQ;
    else if (dynSelQ != '0)  upperOut = dynSelQ;
    else if (staticSel != '0) upperOut = staticSel;
    else                     upperOut = '0;
  end

  assign memAddr    = ctl.rdInd ? lowQ : (ctl.rdTbl1 ? tblQ + DW'(DESC_STEP) : tblQ);
  assign chunkAddr  = {upperOut, lowQ};
  assign remainZero = (remainQ == '0);
  assign errIllegal = errQ;
  assign totalCount = totalQ;
  assign nextPtr    = nextQ;
  assign instAddr   = instQ;
endmodule

// File: rtl/bm_addr_composer.sv
module bm_addr_composer
  import bm_addr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              moveKind,
  input  logic [MODE_W-1:0]       modeCtl,
  input  logic [CNT_W-1:0]        insnCount,
  input  logic [DW-1:0]           insnArg,
  input  logic [DW-1:0]           insnExtra,
  input  logic [DW-1:0]           scriptPtr,
  input  logic [DW-1:0]           descBase,
  input  logic [N_SCRATCH*DW-1:0] scratchBank,
  input  logic [DW-1:0]           mmRdSel,
  input  logic [DW-1:0]           mmWrSel,
  input  logic [DW-1:0]           fetchSel,
  input  logic [DW-1:0]           dynRegSel,
  input  logic [DW-1:0]           staticSel,
  output logic                    memRdEn,
  output logic [DW-1:0]           memAddr,
  input  logic                    memRdValid,
  input  logic [DW-1:0]           memRdData,
  input  logic [CNT_W-1:0]        availLen,
  output logic                    chunkValid,
  input  logic                    chunkReady,
  output logic [2*DW-1:0]         chunkAddr,
  output logic [CNT_W-1:0]        chunkLen,
  output logic                    busy,
  output logic                    done,
  output logic                    errIllegal,
  output logic [TOT_W-1:0]        totalCount,
  output logic [DW-1:0]           nextPtr,
  output logic [DW-1:0]           instAddr
);
  dpCtl_t ctl;
  logic   remainZero, selIllegal;

  bm_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .moveKind(moveKind),
    .memRdValid(memRdValid), .remainZero(remainZero), .selIllegal(selIllegal),
    .ctl(ctl), .memRdEn(memRdEn), .busy(busy), .done(done)
  );

  bm_addr_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .moveKind(moveKind), .modeCtl(modeCtl),
    .insnCount(insnCount), .insnArg(insnArg), .insnExtra(insnExtra),
    .scriptPtr(scriptPtr), .descBase(descBase), .scratchBank(scratchBank),
    .mmRdSel(mmRdSel), .mmWrSel(mmWrSel), .fetchSel(fetchSel),
    .dynRegSel(dynRegSel), .staticSel(staticSel), .memRdValid(memRdValid),
    .memRdData(memRdData), .availLen(availLen), .chunkReady(chunkReady),
    .memAddr(memAddr), .chunkValid(chunkValid), .chunkAddr(chunkAddr),
    .chunkLen(chunkLen), .errIllegal(errIllegal), .totalCount(totalCount),
    .nextPtr(nextPtr), .instAddr(instAddr), .remainZero(remainZero),
    .selIllegal(selIllegal)
  );
endmodule

// File: rtl/bm_addr_chk.sv
module bm_addr_chk
  import bm_addr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic [DW-1:0]     memAddr,
  input logic              memRdValid,
  input logic [CNT_W-1:0]  availLen,
  input logic              chunkValid,
  input logic              chunkReady,
  input logic [2*DW-1:0]   chunkAddr,
  input logic [CNT_W-1:0]  chunkLen,
  input logic              busy,
  input logic              done,
  input logic              errIllegal,
  input logic [TOT_W-1:0]  totalCount
);
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid |-> (chunkLen != '0) && (chunkLen <= availLen) && busy); // R8

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady) |=> totalCount == $past(totalCount) + TOT_W'($past(chunkLen))); // R9

  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(chunkValid && chunkReady) |=> $stable(totalCount)); // R9

  AST_LOW_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady) |=> chunkAddr[DW-1:0] == $past(chunkAddr[DW-1:0]) + DW'($past(chunkLen))); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memRdValid) |=> memRdEn && $stable(memAddr)); // R3

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errIllegal |-> !busy && !chunkValid); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R11
endmodule

bind bm_addr_composer bm_addr_chk u_chk (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memAddr(memAddr),
  .memRdValid(memRdValid), .availLen(availLen), .chunkValid(chunkValid),
  .chunkReady(chunkReady), .chunkAddr(chunkAddr), .chunkLen(chunkLen),
  .busy(busy), .done(done), .errIllegal(errIllegal), .totalCount(totalCount)
);

// File: tb/bm_addr_composer_tb.sv
module bm_addr_composer_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, start, memRdEn, memRdValid, chunkValid, chunkReady, busy, done, errIllegal;
  logic [1:0]  moveKind;
  logic [2:0]  modeCtl;
  logic [23:0] insnCount, availLen, chunkLen;
  logic [31:0] insnArg, insnExtra, scriptPtr, descBase, mmRdSel, mmWrSel, fetchSel;
  logic [31:0] dynRegSel, staticSel, memAddr, memRdData, totalCount, nextPtr, instAddr;
  logic [511:0] scratchBank;
  logic [63:0] chunkAddr;
  logic [31:0] scr [16];

  always_comb for (int i = 0; i < 16; i++) scratchBank[i*32 +: 32] = scr[i];

  bm_addr_composer u_dut (.*);

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [31:0] memA [logic [31:0]];

  // reference model state
  int          mPhase = 0; // 0 idle 1 indirect 2 desc0 3 desc1 4 transfer
  logic [2:0]  mMode = '0;
  logic [23:0] mRemain = '0;
  logic [31:0] mLow = '0, mUpper = '0, mDyn = '0, mTot = '0, mTbl = '0, mDesc0 = '0;
  logic [31:0] mNext = '0, mInst = '0;
  logic        mErr = 1'b0;
  bit          pStart = 0;
  int          memLat = 0, memWait = 0;

  function automatic logic [31:0] memGet(logic [31:0] a);
    if (memA.exists(a)) return memA[a];
    return 32'h0;
  endfunction

  function automatic bit m40(); return mMode[2] & mMode[1]; endfunction
  function automatic bit mTi(); return mMode[1]; endfunction
  function automatic bit badSel(logic [31:0] d0);
    return mTi() && !m40() && (d0[28:24] > 5'd21);
  endfunction

  function automatic logic [31:0] expUpper();
    if (m40() || mTi()) return mUpper;
    if (mDyn != 0) return mDyn;
    if (staticSel != 0) return staticSel;
    return 32'h0;
  endfunction

  function automatic logic [31:0] selPick(logic [4:0] s);
    if (s < 5'd16) return scr[s];
    case (s)
      5'd16: return mmRdSel;
      5'd17: return mmWrSel;
      5'd18: return fetchSel;
      5'd19: return dynRegSel;
      5'd20: return staticSel;
      default: return mDyn;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expMemAddr();
    if (mPhase == 1) return mLow;
    if (mPhase == 3) return mTbl + 32'd4;
    return mTbl;
  endfunction

  task automatic compareAll();
    bit expValid, expDone, expRd;
    string upTag;
    expValid = (mPhase == 4) && (mRemain != 0) && (availLen != 0);
    expRd    = (mPhase >= 1) && (mPhase <= 3);
    expDone  = ((mPhase == 4) && (mRemain == 0)) ||
               ((mPhase == 3) && memRdValid && badSel(mDesc0));
    upTag    = m40() ? "R2" : (mTi() ? "R4" : "R7");
    chk("R12", "busy", 64'(busy), 64'(mPhase != 0));
    chk("R3", "memRdEn", 64'(memRdEn), 64'(expRd));
    if (expRd) chk(mPhase == 1 ? "R10" : "R3", "memAddr", 64'(memAddr), 64'(expMemAddr()));
    chk("R8", "chunkValid", 64'(chunkValid), 64'(expValid));
    if (expValid) begin
      chk("R8", "chunkLen", 64'(chunkLen), 64'((mRemain < availLen) ? mRemain : availLen));
      chk("R9", "lowAddr", 64'(chunkAddr[31:0]), 64'(mLow));
      chk(upTag, "upperAddr", 64'(chunkAddr[63:32]), 64'(expUpper()));
    end
    chk("R11", "done", 64'(done), 64'(expDone));
    chk("R5", "errIllegal", 64'(errIllegal), 64'(mErr));
    chk("R9", "totalCount", 64'(totalCount), 64'(mTot));
    chk("R6", "nextPtr", 64'(nextPtr), 64'(mNext));
    chk("R6", "instAddr", 64'(instAddr), 64'(mInst));
  endtask

  task automatic modelStep();
    logic [23:0] len;
    case (mPhase)
      0: if (start) begin
        mMode = modeCtl; mRemain = insnCount; mLow = insnArg; mUpper = 0; mErr = 0;
        mTbl  = descBase + {{8{insnArg[23]}}, insnArg[23:0]};
        mInst = scriptPtr - 32'd8;
        if (moveKind == 2'd0 && modeCtl[0]) begin mDyn = insnExtra; mNext = scriptPtr + 32'd4; end
        else mNext = scriptPtr;
        mPhase = (moveKind == 2'd1) ? 1 : (moveKind == 2'd2) ? 2 : 4;
      end
      1: if (memRdValid) begin mLow = memRdData; mPhase = 4; end
      2: if (memRdValid) begin mDesc0 = memRdData; mRemain = memRdData[23:0]; mPhase = 3; end
      3: if (memRdValid) begin
        mLow = memRdData;
        if (m40()) begin mUpper = {24'h0, mDesc0[31:24]}; mPhase = 4; end
        else if (mTi()) begin
          if (badSel(mDesc0)) begin mErr = 1; mUpper = 0; mPhase = 0; end
          else begin mUpper = selPick(mDesc0[28:24]); mPhase = 4; end
        end else begin mUpper = 0; mPhase = 4; end
      end
      4: begin
        if (mRemain == 0) mPhase = 0;
        else if (chunkReady && availLen != 0) begin
          len = (mRemain < availLen) ? mRemain : availLen;
          mLow = mLow + 32'(len); mRemain = mRemain - len; mTot = mTot + 32'(len);
        end
      end
      default: mPhase = 0;
    endcase
  endtask

  task automatic cycle();
    @(negedge clk);
    compareAll();
    start      = pStart;
    availLen   = ($urandom % 4 == 0) ? 24'd0 : 24'(($urandom % 48) + 1);
    chunkReady = ($urandom % 3) != 0;
    if (mPhase >= 1 && mPhase <= 3) begin
      if (memWait > 0) begin memRdValid = 0; memWait--; memRdData = $urandom; end
      else begin memRdValid = 1; memRdData = memGet(expMemAddr()); memWait = memLat; end
    end else begin
      memRdValid = 0; memRdData = $urandom; memWait = memLat;
    end
    modelStep();
  endtask

  task automatic runMove(logic [1:0] k, logic [2:0] m, logic [23:0] c, logic [31:0] a,
                         logic [31:0] x, logic [31:0] p);
    int n;
    moveKind = k; modeCtl = m; insnCount = c; insnArg = a; insnExtra = x; scriptPtr = p;
    pStart = 1; cycle(); pStart = 0;
    n = 0;
    while (mPhase != 0 && n < 4000) begin cycle(); n++; end
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; start = 0; moveKind = 0; modeCtl = 0; insnCount = 0; insnArg = 0;
    insnExtra = 0; scriptPtr = 0; descBase = 0; memRdValid = 0; memRdData = 0;
    availLen = 0; chunkReady = 0; staticSel = 0;
    mmRdSel = 32'hA0A0_0010; mmWrSel = 32'hA0A0_0011; fetchSel = 32'hA0A0_0012;
    dynRegSel = 32'hA0A0_0013;
    for (int i = 0; i < 16; i++) scr[i] = 32'h5C00_0000 + 32'(i * 32'h111);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: state right after reset
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "chunkValid", 64'(chunkValid), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "errIllegal", 64'(errIllegal), 64'd0);
    chk("R1", "totalCount", 64'(totalCount), 64'd0);
    chk("R1", "upperAddr", 64'(chunkAddr[63:32]), 64'd0);

    // R7/R8/R9: plain direct move, all selectors zero
    runMove(2'd0, 3'd0, 24'd100, 32'h0000_1000, 32'h0, 32'h0000_0200);
    // R7: static selector used when dynamic is zero
    staticSel = 32'h1111_2222;
    runMove(2'd0, 3'd0, 24'd77, 32'h0010_0000, 32'h0, 32'h0000_0300);
    // R6: direct 64-bit loads the dynamic selector, pointer +4
    runMove(2'd0, 3'd1, 24'd60, 32'h0020_0000, 32'hCAFE_0001, 32'h0000_1000);
    // R7: dynamic beats static
    runMove(2'd0, 3'd0, 24'd33, 32'h0030_0000, 32'h0, 32'h0000_1100);
    // R10: indirect fetch of the low address
    memLat = 1;
    memA[32'h0000_2000] = 32'h8000_0000;
    runMove(2'd1, 3'd0, 24'd50, 32'h0000_2000, 32'h0, 32'h0000_1200);
    // R2/R3: 40-bit table move, negative offset
    memLat = 2;
    descBase = 32'h0000_4000;
    memA[32'h0000_3FF0] = {8'h5A, 24'd90};
    memA[32'h0000_3FF4] = 32'h9000_0000;
    runMove(2'd2, 3'd6, 24'd0, 32'h00FF_FFF0, 32'h0, 32'h0000_1300);
    // R2: direct move in 40-bit mode keeps zero upper bits
    runMove(2'd0, 3'd6, 24'd20, 32'h0040_0000, 32'h0, 32'h0000_1400);
    // R2: bit 2 alone enables no wide mode
    runMove(2'd2, 3'd4, 24'd0, 32'h0000_0FF0, 32'h0, 32'h0000_1500);
    memLat = 0;
    // R4: every legal selector in descriptor 64-bit mode
    for (int s = 0; s < 22; s++) begin
      memA[32'h0000_4100] = {3'b101, 5'(s), 24'(10 + s)};
      memA[32'h0000_4104] = 32'h7000_0000 + 32'(s * 256);
      runMove(2'd2, 3'd2, 24'd0, 32'h0000_0100, 32'h0, 32'h0000_2000);
    end
    // R5: illegal selectors abort with error
    memA[32'h0000_4200] = {3'b000, 5'h16, 24'd40};
    memA[32'h0000_4204] = 32'h6000_0000;
    runMove(2'd2, 3'd2, 24'd0, 32'h0000_0200, 32'h0, 32'h0000_2100);
    memA[32'h0000_4200] = {3'b111, 5'h1F, 24'd40};
    runMove(2'd2, 3'd2, 24'd0, 32'h0000_0200, 32'h0, 32'h0000_2200);
    // R5: next start clears the flag; R11: zero count finishes without a chunk
    runMove(2'd0, 3'd0, 24'd0, 32'h0050_0000, 32'h0, 32'h0000_2300);
    memA[32'h0000_4300] = {8'h00, 24'd0};
    runMove(2'd2, 3'd0, 24'd0, 32'h0000_0300, 32'h0, 32'h0000_2400);
    // R12: start while busy is ignored
    moveKind = 2'd0; modeCtl = 3'd0; insnCount = 24'd300; insnArg = 32'h0060_0000;
    scriptPtr = 32'h0000_2500;
    pStart = 1; cycle(); pStart = 0;
    repeat (3) cycle();
    moveKind = 2'd2; modeCtl = 3'd1; insnCount = 24'd5; insnArg = 32'h0000_0300;
    insnExtra = 32'hDEAD_BEEF; scriptPtr = 32'h0000_9999;
    pStart = 1; cycle(); pStart = 0;
    begin
      int n = 0;
      while (mPhase != 0 && n < 4000) begin cycle(); n++; end
    end
    cycle();
    // R9: long move with heavy back-pressure
    runMove(2'd0, 3'd0, 24'd500, 32'hFFFF_FF00, 32'h0, 32'h0000_2600);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule